// File: doc/BRIEF.md
# Per-Area Chip-Select Stretching Bus Sequencer

This block runs single accesses on a simple external memory and I/O bus whose address space is split into eight areas. A requester presents an address, a direction and write data. The block then decodes the area from the top address bits and steps through a short series of bus states. In those states it drives one active-low chip-select per area, the address lines, separate read and write strobes, and the write data. Completion is reported with a busy level and a one-cycle done pulse, and read data is returned with that pulse.

Two small control registers each hold one bit per area, and software can write and read both. A set bit in the lead register puts one extra state in front of the normal two-state access. A set bit in the trail register puts one extra state after it. In the added states only the area's chip-select and the address are driven. Both strobes stay high and write data is not driven. This widens the window around the strobe for slow peripherals. The bits are captured when an access starts, so register writes made during an access only affect later ones.

Top module: `csx_bus_seq`

## Requirements
- R1: After reset both control registers read 0, every chip-select is high, both strobes are high, the address lines are 0, busy and done are low. While the bus is idle these output values hold.
- R2: cfg_sel=0 selects the lead register and cfg_sel=1 selects the trail register. A write with cfg_we=1 takes effect at the next clock edge. cfg_rdata always shows the selected register, and bit n of each register belongs to area n.
- R3: The area is req_addr[ADDR_W-1 -: 3]. During an access only bus_cs_n[area] is low, and it stays unchanged from the first state to the last.
- R4: With both bits of the area clear, an access lasts exactly two states. No strobe is active in the first state. The direction's strobe is low in the second state only, and the two strobes are never low together.
- R5: With the lead bit of the area set, one extra state comes before the two normal states. In that state chip-select and address are driven, both strobes are high and bus_dout_en is 0.
- R6: With the trail bit of the area set, one extra state follows the two normal states. In that state chip-select and the address stay driven, both strobes are high and bus_dout_en is 0.
- R7: For a write, bus_dout_en is 1 and bus_dout equals the write data in both normal states. In every other state bus_dout_en is 0 and bus_dout is 0.
- R8: For a read, bus_din is captured at the end of the second normal state and presented on rd_data when done pulses.
- R9: Requests are accepted only while busy is low, and they are ignored while busy is high. busy is high for exactly the states of the sequence. done is high for one cycle, in the first idle cycle after the last state.
- R10: The lead and trail bits are sampled when an access is accepted. Register writes during the access do not change its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_sel | input | 1 | 0 selects the lead register, 1 selects the trail register |
| cfg_wdata | input | N_AREAS | Control register write value |
| cfg_rdata | output | N_AREAS | Selected control register contents |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_cs_n | output | N_AREAS | Active-low chip-select, one per area |
| bus_addr | output | ADDR_W | Bus address, 0 when idle |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |

## Verification
The bench uses the defaults: a 16-bit address, 8-bit data and three area bits, which gives eight areas. Random addresses therefore hit every area under all four combinations of lead and trail bits. Directed accesses cover areas 0 and 7 at the edges, register writes made in the middle of an access, and requests held high while the block is busy. The narrow data width lets random read values and write data cover every bit often.

// File: rtl/csx_pkg.sv
package csx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_T1,
        PH_T2,
        PH_TRAIL
    } phase_e;
endpackage

// File: rtl/csx_ctrl_regs.sv
module csx_ctrl_regs #(
    parameter int N_AREAS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               sel,
    input  logic [N_AREAS-1:0] wdata,
    output logic [N_AREAS-1:0] rdata,
    output logic [N_AREAS-1:0] lead_mask,
    output logic [N_AREAS-1:0] trail_mask
);
    localparam int N_REGS = 2;

    logic [N_AREAS-1:0] mask_d [N_REGS];
    logic [N_AREAS-1:0] mask_q [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_comb begin
            mask_d[g] = mask_q[g];
            if (we && (sel == 1'(g))) begin
                mask_d[g] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= '0;
            end else begin
                mask_q[g] <= mask_d[g];
            end
        end
    end

    assign lead_mask  = mask_q[0];
    assign trail_mask = mask_q[1];
    assign rdata      = sel ? mask_q[1] : mask_q[0];
endmodule

// File: rtl/csx_area_decode.sv
module csx_area_decode #(
    parameter int AREA_BITS = 3,
    localparam int N_AREAS  = 1 << AREA_BITS
) (
    input  logic                 active,
    input  logic [AREA_BITS-1:0] area,
    output logic [N_AREAS-1:0]   cs_n
);
    for (genvar i = 0; i < N_AREAS; i++) begin : g_sel
        assign cs_n[i] = !(active && (area == AREA_BITS'(i)));
    end
endmodule

// File: rtl/csx_seq_fsm.sv
module csx_seq_fsm
    import csx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int AREA_BITS = 3,
    localparam int N_AREAS  = 1 << AREA_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [N_AREAS-1:0]   lead_mask,
    input  logic [N_AREAS-1:0]   trail_mask,
    input  logic [DATA_W-1:0]    bus_din,
    output logic                 active,
    output logic [AREA_BITS-1:0] area,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic [DATA_W-1:0]    bus_dout,
    output logic                 bus_dout_en,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data
);
    typedef struct packed {
        phase_e                phase;
        logic                  write;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
        logic [AREA_BITS-1:0]  area;
        logic                  trail;
        logic [DATA_W-1:0]     rdata;
        logic                  done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [AREA_BITS-1:0] req_area;
    logic                 in_normal;

    assign req_area = req_addr[ADDR_W-1 -: AREA_BITS];

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.write = req_write;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.area  = req_area;
                    seq_d.trail = trail_mask[req_area];
                    seq_d.phase = lead_mask[req_area] ? PH_LEAD : PH_T1;
                end
            end
            PH_LEAD: seq_d.phase = PH_T1;
            PH_T1:   seq_d.phase = PH_T2;
            PH_T2: begin
                if (!seq_q.write) begin
                    seq_d.rdata = bus_din;
                end
                if (seq_q.trail) begin
                    seq_d.phase = PH_TRAIL;
                end else begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            PH_TRAIL: begin
                seq_d.phase = PH_IDLE;
                seq_d.done  = 1'b1;
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active      = (seq_q.phase != PH_IDLE);
    assign in_normal   = (seq_q.phase == PH_T1) || (seq_q.phase == PH_T2);
    assign area        = seq_q.area;
    assign bus_addr    = active ? seq_q.addr : '0;
    assign bus_rd_n    = !((seq_q.phase == PH_T2) && !seq_q.write);
    assign bus_wr_n    = !((seq_q.phase == PH_T2) && seq_q.write);
    assign bus_dout_en = seq_q.write && in_normal;
    assign bus_dout    = bus_dout_en ? seq_q.wdata : '0;
    assign busy        = active;
    assign done        = seq_q.done;
    assign rd_data     = seq_q.rdata;
endmodule

// File: rtl/csx_bus_seq.sv
module csx_bus_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int AREA_BITS = 3,
    localparam int N_AREAS  = 1 << AREA_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [N_AREAS-1:0] cfg_wdata,
    output logic [N_AREAS-1:0] cfg_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic [N_AREAS-1:0] bus_cs_n,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_rd_n,
    output logic               bus_wr_n,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_dout_en,
    input  logic [DATA_W-1:0]  bus_din
);
    logic [N_AREAS-1:0]   lead_mask;
    logic [N_AREAS-1:0]   trail_mask;
    logic                 seq_active;
    logic [AREA_BITS-1:0] seq_area;

    csx_ctrl_regs #(.N_AREAS(N_AREAS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .lead_mask  (lead_mask),
        .trail_mask (trail_mask)
    );

    csx_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .AREA_BITS (AREA_BITS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .lead_mask   (lead_mask),
        .trail_mask  (trail_mask),
        .bus_din     (bus_din),
        .active      (seq_active),
        .area        (seq_area),
        .bus_addr    (bus_addr),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data)
    );

    csx_area_decode #(.AREA_BITS(AREA_BITS)) u_dec (
        .active (seq_active),
        .area   (seq_area),
        .cs_n   (bus_cs_n)
    );
endmodule

// File: rtl/csx_bus_seq_chk.sv
module csx_bus_seq_chk #(
    parameter int N_AREAS = 8,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic [N_AREAS-1:0] cs_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               rd_n,
    input logic               wr_n,
    input logic               dout_en
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((&cs_n) && rd_n && wr_n && (addr == '0))); // R1
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R3
    AST_BUSY_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(&cs_n)); // R3
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n)); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R4
    AST_RD_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n); // R4
    AST_WR_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> wr_n); // R7
    AST_WR_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> dout_en); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
endmodule

bind csx_bus_seq csx_bus_seq_chk #(
    .N_AREAS (N_AREAS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .cs_n    (bus_cs_n),
    .addr    (bus_addr),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .dout_en (bus_dout_en)
);

// File: tb/csx_bus_seq_bench.sv
module csx_bus_seq_bench;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int N_AREAS = 8;
    localparam int K_LEAD  = 0;
    localparam int K_T1    = 1;
    localparam int K_T2    = 2;
    localparam int K_TRAIL = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic               cfg_sel = 1'b0;
    logic [N_AREAS-1:0] cfg_wdata = '0;
    logic [N_AREAS-1:0] cfg_rdata;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               busy, done;
    logic [DATA_W-1:0]  rd_data;
    logic [N_AREAS-1:0] bus_cs_n;
    logic [ADDR_W-1:0]  bus_addr;
    logic               bus_rd_n, bus_wr_n, bus_dout_en;
    logic [DATA_W-1:0]  bus_dout;
    logic [DATA_W-1:0]  bus_din = '0;

    int vectors = 0;
    int fails   = 0;
    logic [N_AREAS-1:0] m_lead  = '0;
    logic [N_AREAS-1:0] m_trail = '0;

    always #5 clk = ~clk;

    csx_bus_seq u_csx_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_rd_n(int k, bit w);
        return !((k == K_T2) && !w);
    endfunction

    function automatic logic exp_wr_n(int k, bit w);
        return !((k == K_T2) && w);
    endfunction

    function automatic logic exp_den(int k, bit w);
        return w && ((k == K_T1) || (k == K_T2));
    endfunction

    function automatic string phase_req(int k);
        if (k == K_LEAD)  return "R5";
        if (k == K_TRAIL) return "R6";
        return "R4";
    endfunction

    task automatic reg_write(bit sel, logic [N_AREAS-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_trail = val; else m_lead = val;
    endtask

    task automatic reg_check(bit sel);
        cfg_sel = sel;
        #1;
        check("R2", sel ? "trail readback" : "lead readback",
              32'(cfg_rdata), 32'(sel ? m_trail : m_lead));
    endtask

    // mid: rewrite both registers during the access; noisy: hold junk requests while busy
    task automatic do_access(bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd,
                             logic [DATA_W-1:0] din, bit mid, bit noisy);
        int kinds[4];
        int n = 0;
        int area = int'(a[ADDR_W-1 -: 3]);
        bit h = m_lead[area];
        bit t = m_trail[area];
        logic [N_AREAS-1:0] exp_cs = ~(N_AREAS'(1) << area);
        if (h) begin kinds[n] = K_LEAD; n++; end
        kinds[n] = K_T1; n++;
        kinds[n] = K_T2; n++;
        if (t) begin kinds[n] = K_TRAIL; n++; end
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd; bus_din = din;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(phase_req(kinds[i]), "busy", 32'(busy), 32'(1));
            check("R3", "cs_n", 32'(bus_cs_n), 32'(exp_cs));
            check(phase_req(kinds[i]), "addr", 32'(bus_addr), 32'(a));
            check(phase_req(kinds[i]), "rd_n", 32'(bus_rd_n), 32'(exp_rd_n(kinds[i], w)));
            check(phase_req(kinds[i]), "wr_n", 32'(bus_wr_n), 32'(exp_wr_n(kinds[i], w)));
            check("R7", "dout_en", 32'(bus_dout_en), 32'(exp_den(kinds[i], w)));
            check("R7", "dout", 32'(bus_dout), 32'(exp_den(kinds[i], w) ? wd : '0));
            check("R9", "done low while busy", 32'(done), 32'(0));
            if (noisy && (i < n - 1)) begin
                req_addr = ~a; req_write = ~w; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            cfg_we = 1'b0;
            if (mid && i == 0) begin
                cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ~m_lead; m_lead = ~m_lead;
            end
            if (mid && i == 1) begin
                cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = ~m_trail; m_trail = ~m_trail;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9", "done pulse", 32'(done), 32'(1));
        check("R9", "busy cleared", 32'(busy), 32'(0));
        check("R1", "cs idle", 32'(bus_cs_n), 32'({N_AREAS{1'b1}}));
        if (mid) check("R10", "sequence length", 32'(n), 32'(2 + int'(h) + int'(t)));
        if (!w) check("R8", "rd_data", 32'(rd_data), 32'(din));
        @(negedge clk);
        check("R9", "done one cycle", 32'(done), 32'(0));
        check(noisy ? "R9" : "R1", "still idle", 32'(busy), 32'(0));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C5A7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cs_n", 32'(bus_cs_n), 32'({N_AREAS{1'b1}}));
        check("R1", "rd_n", 32'(bus_rd_n), 32'(1));
        check("R1", "wr_n", 32'(bus_wr_n), 32'(1));
        check("R1", "addr", 32'(bus_addr), 32'(0));
        check("R1", "busy", 32'(busy), 32'(0));
        check("R1", "done", 32'(done), 32'(0));
        cfg_sel = 1'b0; #1;
        check("R1", "lead reg", 32'(cfg_rdata), 32'(0));
        cfg_sel = 1'b1; #1;
        check("R1", "trail reg", 32'(cfg_rdata), 32'(0));

        // R2 register access
        reg_write(1'b0, 8'hA5); reg_check(1'b0); reg_check(1'b1);
        reg_write(1'b1, 8'h3C); reg_check(1'b1); reg_check(1'b0);

        // R4 plain accesses at the area edges
        reg_write(1'b0, 8'h00); reg_write(1'b1, 8'h00);
        do_access(1'b0, 16'h0123, 8'h00, 8'h5A, 1'b0, 1'b0);
        do_access(1'b1, 16'hFFFE, 8'hC3, 8'h00, 1'b0, 1'b0);

        // R5 R6 lead only area 2, trail only area 5, both area 6
        reg_write(1'b0, 8'h44); reg_write(1'b1, 8'h60);
        do_access(1'b0, 16'h4010, 8'h00, 8'h96, 1'b0, 1'b0);
        do_access(1'b1, 16'hA020, 8'h7E, 8'h00, 1'b0, 1'b0);
        do_access(1'b0, 16'hC030, 8'h00, 8'hE1, 1'b0, 1'b0);
        do_access(1'b1, 16'hC8F0, 8'h18, 8'h00, 1'b0, 1'b0);

        // R10 register rewrite mid-access, R9 requests while busy
        do_access(1'b0, 16'hC555, 8'h00, 8'h3B, 1'b1, 1'b0);
        do_access(1'b1, 16'h4AAA, 8'h81, 8'h00, 1'b1, 1'b1);
        do_access(1'b0, 16'h2222, 8'h00, 8'hD4, 1'b0, 1'b1);
        reg_check(1'b0); reg_check(1'b1);

        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0) begin
                reg_write(1'b0, N_AREAS'($urandom));
                reg_write(1'b1, N_AREAS'($urandom));
                reg_check(1'b0); reg_check(1'b1);
            end
            do_access(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom), DATA_W'($urandom),
                      ($urandom % 16) == 0, ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule